// File: doc/BRIEF.md
# Secondary Code and Primary-Period Epoch Sequencer

This block paces extended coherent integration in a satellite-signal tracking channel. It counts incoming samples to mark the boundary of each primary-code period. At each boundary it steps through up to two stored secondary codes, one chip per period. The first period after an integration start can have its own programmed sample length, and every later period uses a second length. This lets software correct a measured deviation in the period that directly follows the start.

Software programs the block through a plain write port. The registers hold a control word, a combined length word for both secondary codes, two period lengths written as length minus one, and one strobed word-load register per code store. Word loads take effect only on a rising edge of the strobe bit. With pilot tracking, store 0 holds the pilot code and store 1 the data code. Without pilot tracking, store 0 holds the data code and store 1 is given length zero.

The sample strobe is a valid-only stream. The block accepts every sample and applies no back-pressure, so there is no ready signal. The epoch output is a one-cycle pulse in the cycle of the last sample of a period. The two chip outputs are registered and take the value for the new period in the cycle after that pulse.

Top module: `sec_code_sequencer`

## Requirements
- R1: The first period after an integration start is FIRST+1 samples long, and every later period is NEXT+1 samples long. `epoch_o` is high in the same cycle as the last sample of each period and low at all other times.
- R2: `epoch_o` is asserted only in a cycle with `sample_vld_i` high. Samples arriving before the first integration start are not counted, and cycles without a sample do not advance the count.
- R3: A pulse on `integ_start_i` abandons the current period and begins a first period. A sample in that same cycle counts as the first sample of the new period, so FIRST=0 gives an epoch in that cycle.
- R4: While enabled, each code pointer advances by one at every epoch and wraps to zero after its programmed length. A chip output shows the stored bit at its pointer, where stored 1 means chip -1 and stored 0 means chip +1. The output changes in the cycle after the epoch.
- R5: While secondary codes are disabled, both chip outputs are 0 (+1) and both pointers are held at zero, so the code restarts at chip 0 when it is re-enabled.
- R6: A store whose programmed length is zero outputs a constant 0 (+1).
- R7: Code-load register layout: bits [19:0] are chips 20*w to 20*w+19 (bit i is chip 20*w+i), bits [22:20] are the word index w, and bit 23 is the strobe. A word is stored only when bit 23 is 1 and the previous write to the same register had bit 23 at 0. Repeated strobe-high writes and strobe-low writes change nothing.
- R8: Control register: bit 1 enables secondary codes. Writing bit 2 as 1 clears both pointers in the same write.
- R9: Register addresses: 0 control, 1 code lengths, 2 code 0 load, 3 code 1 load, 4 FIRST, 5 NEXT. FIRST and NEXT are in bits [23:0]. The code 0 length is in bits [7:0] and the code 1 length in bits [23:16], each from 0 to 160 chips.
- R10: After reset the block is disabled, all lengths are 0, both stores are clear, no period is running, `epoch_o` is 0 and both chips are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Register write enable |
| cfg_addr_i | input | 3 | Register address |
| cfg_data_i | input | 32 | Register write data |
| sample_vld_i | input | 1 | One input sample this cycle |
| integ_start_i | input | 1 | Integration start pulse |
| chip0_o | output | 1 | Current chip of code 0 (1 = -1) |
| chip1_o | output | 1 | Current chip of code 1 (1 = -1) |
| epoch_o | output | 1 | Last sample of a primary-code period |

## Verification
On every cycle the assertions check that an epoch always coincides with a sample and with a started sequence. They also check that pointers and chip outputs move only after an epoch or a register write, and that a disabled block holds its pointers at zero. The bench scenarios show the properties that depend on configuration history. These are the first-versus-later period lengths, restarts in mid-period, wrap points at the exact programmed code length including the 160-chip maximum, the rule that loads occur only on a strobe edge, and the absent-code case.

// File: rtl/scs_pkg.sv
package scs_pkg;
  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_LENS  = 3'd1,
    A_CODE0 = 3'd2,
    A_CODE1 = 3'd3,
    A_FIRST = 3'd4,
    A_NEXT  = 3'd5
  } cfg_addr_e;

  localparam int CTRL_EN_BIT    = 1;
  localparam int CTRL_CLR_BIT   = 2;
  localparam int CODE_STB_BIT   = 23;
  localparam int CODE_WADDR_LSB = 20;
  localparam int LEN1_LSB       = 16;
endpackage

// File: rtl/scs_cfg_regs.sv
module scs_cfg_regs
  import scs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8,
  parameter int PER_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [2:0]        addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              en_o,
  output logic              clr_o,
  output logic [LEN_W-1:0]  len0_o,
  output logic [LEN_W-1:0]  len1_o,
  output logic [PER_W-1:0]  first_m1_o,
  output logic [PER_W-1:0]  next_m1_o,
  output logic [1:0]        code_sel_o
);
  cfg_addr_e a;
  logic      unused_bits;

  assign a           = cfg_addr_e'(addr_i);
  assign unused_bits = ^data_i;

  // pointer clear acts in the same write
  assign clr_o         = wr_i && (a == A_CTRL) && data_i[CTRL_CLR_BIT];
  assign code_sel_o[0] = wr_i && (a == A_CODE0);
  assign code_sel_o[1] = wr_i && (a == A_CODE1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_o       <= 1'b0;
      len0_o     <= '0;
      len1_o     <= '0;
      first_m1_o <= '0;
      next_m1_o  <= '0;
    end else if (wr_i) begin
      case (a)
        A_CTRL:  en_o       <= data_i[CTRL_EN_BIT];
        A_LENS: begin
          len0_o <= data_i[LEN_W-1:0];
          len1_o <= data_i[LEN1_LSB +: LEN_W];
        end
        A_FIRST: first_m1_o <= data_i[PER_W-1:0];
        A_NEXT:  next_m1_o  <= data_i[PER_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/scs_code_store.sv
module scs_code_store
  import scs_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int WORD_W  = 20,
  parameter int WADDR_W = 3,
  parameter int PTR_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [PTR_W-1:0]  ptr_i,
  output logic              bit_o
);
  localparam int DEPTH = WORD_W << WADDR_W;

  logic [DEPTH-1:0]   mem_q;
  logic               stb_q;
  logic               stb;
  logic [WADDR_W-1:0] waddr;
  int                 base;
  logic               unused_bits;

  assign stb         = data_i[CODE_STB_BIT];
  assign waddr       = data_i[CODE_WADDR_LSB +: WADDR_W];
  assign unused_bits = ^data_i;

  always_comb base = int'(waddr) * WORD_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
      stb_q <= 1'b0;
    end else if (sel_i) begin
      stb_q <= stb;
      if (stb && !stb_q) begin
        for (int i = 0; i < WORD_W; i++) mem_q[base + i] <= data_i[i];
      end
    end
  end

  assign bit_o = (int'(ptr_i) < DEPTH) ? mem_q[ptr_i] : 1'b0;
endmodule

// File: rtl/scs_period_timer.sv
module scs_period_timer #(
  parameter int PER_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_i,
  input  logic             start_i,
  input  logic [PER_W-1:0] first_m1_i,
  input  logic [PER_W-1:0] next_m1_i,
  output logic             epoch_o,
  output logic             run_o
);
  logic [PER_W-1:0] cnt_q, eff_cnt, limit;
  logic             first_q, run_q, eff_first, active;

  always_comb begin
    eff_first = start_i | first_q;
    eff_cnt   = start_i ? '0 : cnt_q;
    limit     = eff_first ? first_m1_i : next_m1_i;
    active    = sample_i & (run_q | start_i);
    epoch_o   = active & (eff_cnt == limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      first_q <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      if (start_i) run_q <= 1'b1;
      if (active) begin
        cnt_q   <= epoch_o ? '0 : eff_cnt + 1'b1;
        first_q <= epoch_o ? 1'b0 : eff_first;
      end else if (start_i) begin
        cnt_q   <= '0;
        first_q <= 1'b1;
      end
    end
  end

  assign run_o = run_q;
endmodule

// File: rtl/scs_chip_ptr.sv
module scs_chip_ptr #(
  parameter int PTR_W = 8,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [PTR_W-1:0] ptr_o
);
  logic wrap;

  assign wrap = (int'(ptr_o) + 1) >= int'(len_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ptr_o <= '0;
    else if (clr_i || !en_i)   ptr_o <= '0;
    else if (step_i)           ptr_o <= wrap ? '0 : ptr_o + 1'b1;
  end
endmodule

// File: rtl/sec_code_sequencer.sv
module sec_code_sequencer #(
  parameter int DATA_W  = 32,
  parameter int WORD_W  = 20,
  parameter int WADDR_W = 3,
  parameter int PER_W   = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_i,
  input  logic [2:0]        cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_data_i,
  input  logic              sample_vld_i,
  input  logic              integ_start_i,
  output logic              chip0_o,
  output logic              chip1_o,
  output logic              epoch_o
);
  localparam int DEPTH = WORD_W << WADDR_W;
  localparam int PTR_W = $clog2(DEPTH);
  localparam int LEN_W = $clog2(DEPTH + 1);

  logic             en_q, clr, running;
  logic [1:0]       code_sel;
  logic [LEN_W-1:0] len [2];
  logic [PER_W-1:0] first_m1, next_m1;
  logic [PTR_W-1:0] ptr [2];
  logic [1:0]       raw_bit, chip;

  scs_cfg_regs #(.DATA_W(DATA_W), .LEN_W(LEN_W), .PER_W(PER_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_i(cfg_wr_i), .addr_i(cfg_addr_i),
    .data_i(cfg_data_i), .en_o(en_q), .clr_o(clr), .len0_o(len[0]),
    .len1_o(len[1]), .first_m1_o(first_m1), .next_m1_o(next_m1),
    .code_sel_o(code_sel)
  );

  scs_period_timer #(.PER_W(PER_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .sample_i(sample_vld_i),
    .start_i(integ_start_i), .first_m1_i(first_m1), .next_m1_i(next_m1),
    .epoch_o(epoch_o), .run_o(running)
  );

  for (genvar g = 0; g < 2; g++) begin : g_code
    scs_code_store #(.DATA_W(DATA_W), .WORD_W(WORD_W), .WADDR_W(WADDR_W),
                     .PTR_W(PTR_W)) u_store (
      .clk(clk), .rst_n(rst_n), .sel_i(code_sel[g]), .data_i(cfg_data_i),
      .ptr_i(ptr[g]), .bit_o(raw_bit[g])
    );
    scs_chip_ptr #(.PTR_W(PTR_W), .LEN_W(LEN_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .en_i(en_q), .clr_i(clr), .step_i(epoch_o),
      .len_i(len[g]), .ptr_o(ptr[g])
    );
    // disabled or absent code reads as +1 (0)
    assign chip[g] = en_q & (len[g] != '0) & raw_bit[g];
  end

  assign chip0_o = chip[0];
  assign chip1_o = chip[1];
endmodule

// File: rtl/scs_checker.sv
module scs_checker #(
  parameter int PTR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sample_vld_i,
  input logic             integ_start_i,
  input logic             cfg_wr_i,
  input logic             epoch_o,
  input logic             chip0_o,
  input logic             chip1_o,
  input logic             en,
  input logic             running,
  input logic [PTR_W-1:0] ptr0,
  input logic [PTR_W-1:0] ptr1
);
  AST_EPOCH_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    epoch_o |-> sample_vld_i);  // R2
  AST_EPOCH_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    epoch_o |-> (running || integ_start_i));  // R2
  AST_PTR0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(epoch_o) && !$past(cfg_wr_i) && $past(en)) |-> $stable(ptr0));  // R4
  AST_PTR1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(epoch_o) && !$past(cfg_wr_i) && $past(en)) |-> $stable(ptr1));  // R4
  AST_CHIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(epoch_o) && !$past(cfg_wr_i)) |-> ($stable(chip0_o) && $stable(chip1_o)));  // R4
  AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (ptr0 == '0 && ptr1 == '0));  // R5
endmodule

bind sec_code_sequencer scs_checker #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_vld_i(sample_vld_i),
  .integ_start_i(integ_start_i), .cfg_wr_i(cfg_wr_i), .epoch_o(epoch_o),
  .chip0_o(chip0_o), .chip1_o(chip1_o), .en(en_q), .running(running),
  .ptr0(ptr[0]), .ptr1(ptr[1])
);

// File: tb/sec_code_sequencer_tb.sv
`timescale 1ns/1ps
module sec_code_sequencer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_i = 1'b0;
  logic [2:0]  cfg_addr_i = '0;
  logic [31:0] cfg_data_i = '0;
  logic        sample_vld_i = 1'b0;
  logic        integ_start_i = 1'b0;
  logic        chip0_o, chip1_o, epoch_o;

  always #2 clk = ~clk;

  sec_code_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr_i), .cfg_addr_i(cfg_addr_i),
    .cfg_data_i(cfg_data_i), .sample_vld_i(sample_vld_i),
    .integ_start_i(integ_start_i), .chip0_o(chip0_o), .chip1_o(chip1_o),
    .epoch_o(epoch_o)
  );

  // reference state
  bit           m_en, m_pv0, m_pv1, m_first, m_run;
  int           m_len0, m_len1, m_f, m_n, m_cnt, m_p0, m_p1;
  logic [159:0] m_c0, m_c1;
  int           n_vec = 0, n_bad = 0;
  bit           finished = 0;

  task automatic chk(input logic got, input logic exp, input string tag, input string what);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, got, exp, $time);
    end
  endtask

  function automatic int nxt_ptr(int p, int len);
    return (p + 1 >= len) ? 0 : p + 1;
  endfunction

  task automatic cyc(input bit vld, input bit st, input bit wr, input logic [2:0] a,
                     input logic [31:0] d, input string tag);
    bit ef, ep, c0, c1, act;
    int ec, lim;
    @(posedge clk); #1;
    sample_vld_i = vld; integ_start_i = st; cfg_wr_i = wr; cfg_addr_i = a; cfg_data_i = d;
    #1;
    ef  = st ? 1'b1 : m_first;
    ec  = st ? 0 : m_cnt;
    lim = ef ? m_f : m_n;
    act = vld && (m_run || st);
    ep  = act && (ec == lim);
    c0  = m_en && m_len0 != 0 && m_c0[m_p0];
    c1  = m_en && m_len1 != 0 && m_c1[m_p1];
    chk(epoch_o, ep, tag, "epoch");
    chk(chip0_o, c0, tag, "chip0");
    chk(chip1_o, c1, tag, "chip1");
    // state after the coming edge
    if (!m_en) begin m_p0 = 0; m_p1 = 0; end
    else if (ep) begin m_p0 = nxt_ptr(m_p0, m_len0); m_p1 = nxt_ptr(m_p1, m_len1); end
    if (act) begin
      m_cnt = ep ? 0 : ec + 1;
      m_first = ep ? 1'b0 : ef;
    end else if (st) begin
      m_cnt = 0; m_first = 1'b1;
    end
    if (st) m_run = 1'b1;
    if (wr) begin
      case (a)
        3'd0: begin m_en = d[1]; if (d[2]) begin m_p0 = 0; m_p1 = 0; end end
        3'd1: begin m_len0 = int'(d[7:0]); m_len1 = int'(d[23:16]); end
        3'd2: begin
          if (d[23] && !m_pv0) m_c0[int'(d[22:20])*20 +: 20] = d[19:0];
          m_pv0 = d[23];
        end
        3'd3: begin
          if (d[23] && !m_pv1) m_c1[int'(d[22:20])*20 +: 20] = d[19:0];
          m_pv1 = d[23];
        end
        3'd4: m_f = int'(d[23:0]);
        3'd5: m_n = int'(d[23:0]);
        default: ;
      endcase
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input string tag);
    cyc(1'b0, 1'b0, 1'b1, a, d, tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, 3'd0, 32'd0, tag);
  endtask

  task automatic run(input int n, input int vld_pct, input int st_pct, input string tag);
    for (int i = 0; i < n; i++)
      cyc(($urandom % 100) < vld_pct, ($urandom % 100) < st_pct, 1'b0, 3'd0, 32'd0, tag);
  endtask

  task automatic load(input int sel, input logic [159:0] code, input string tag);
    for (int w = 0; w < 8; w++) begin
      logic [19:0] word;
      word = code[w*20 +: 20];
      wr(3'(2 + sel), {8'h0, 1'b1, 3'(w), word}, tag);
      // strobe low with junk payload: must store nothing (R7)
      wr(3'(2 + sel), {8'h0, 1'b0, 3'(w), ~word}, tag);
    end
  endtask

  function automatic logic [159:0] rnd_code();
    logic [159:0] c;
    for (int i = 0; i < 5; i++) c[i*32 +: 32] = $urandom;
    return c;
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EC0_1234));
    m_c0 = '0; m_c1 = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // reset state and no counting before a start
    idle(2, "R10");
    run(10, 100, 0, "R2");

    // basic periods and stepping
    load(0, rnd_code(), "R7");
    load(1, rnd_code(), "R7");
    wr(3'd1, {8'd0, 8'd5, 8'd0, 8'd7}, "R9");
    wr(3'd4, 32'd4, "R9");
    wr(3'd5, 32'd2, "R9");
    wr(3'd0, 32'h2, "R8");
    cyc(1'b0, 1'b1, 1'b0, 3'd0, 32'd0, "R1");
    run(60, 100, 0, "R1");
    run(80, 50, 0, "R2");

    // restart: same-cycle sample with FIRST=0, then mid-period restarts
    wr(3'd4, 32'd0, "R3");
    cyc(1'b1, 1'b1, 1'b0, 3'd0, 32'd0, "R3");
    run(5, 100, 0, "R3");
    wr(3'd4, 32'd6, "R3");
    run(3, 100, 0, "R3");
    cyc(1'b1, 1'b1, 1'b0, 3'd0, 32'd0, "R3");
    run(40, 100, 10, "R3");

    // strobe must rise to store: second strobe-high write is dropped
    wr(3'd2, {8'h0, 1'b1, 3'd0, 20'hF0F0F}, "R7");
    wr(3'd2, {8'h0, 1'b1, 3'd0, 20'h0F0F0}, "R7");
    wr(3'd2, {8'h0, 1'b0, 3'd0, 20'h33333}, "R7");
    wr(3'd1, {8'd0, 8'd5, 8'd0, 8'd20}, "R7");
    wr(3'd0, 32'h6, "R8");
    run(50, 100, 0, "R7");

    // disable then re-enable
    wr(3'd0, 32'h0, "R5");
    run(20, 100, 0, "R5");
    wr(3'd0, 32'h2, "R5");
    run(30, 100, 0, "R5");

    // absent data code
    wr(3'd1, {8'd0, 8'd0, 8'd0, 8'd9}, "R6");
    run(40, 100, 0, "R6");

    // maximum length wrap with one-sample periods
    wr(3'd1, {8'd0, 8'd1, 8'd0, 8'd160}, "R9");
    wr(3'd4, 32'd0, "R9");
    wr(3'd5, 32'd0, "R9");
    wr(3'd0, 32'h6, "R9");
    cyc(1'b0, 1'b1, 1'b0, 3'd0, 32'd0, "R9");
    run(170, 100, 0, "R9");

    // random rounds
    for (int r = 0; r < 8; r++) begin
      int l0, l1;
      load(0, rnd_code(), "R7");
      load(1, rnd_code(), "R7");
      l0 = 1 + ($urandom % 160);
      l1 = (($urandom % 4) == 0) ? 0 : 1 + ($urandom % 160);
      wr(3'd1, {8'd0, 8'(l1), 8'd0, 8'(l0)}, "R9");
      wr(3'd4, $urandom % 6, "R1");
      wr(3'd5, $urandom % 6, "R1");
      wr(3'd0, (($urandom % 5) == 0) ? 32'h4 : 32'h6, "R8");
      run(250, 70, 2, "R4");
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule